// File: doc/BRIEF.md
# Self-Calibrating Seconds Tick Divider

This block turns a slow crystal clock, nominally 32768 Hz, into a one-cycle tick once per second. The crystal is not trimmed. Instead, the divide ratio is a stored value close to the nominal figure. The block learns that value by counting crystal cycles between two rising edges of an external precision one-second reference. One count of divisor equals roughly 30 ppm, or about 2.6 s per day. That is the finest correction the block can make.

Software or a pin raises `cal_en` while the reference is present. The block then arms, starts counting on the next reference edge and stops on the edge after that. It stores the count if the count lies inside a window around nominal. Otherwise it raises an error flag and keeps the old divisor. The tick generator runs at all times. It is a down-counter that reloads from the stored divisor, so a new divisor takes effect from the next reload.

The calibration controller is a four-state machine:
- `ST_IDLE`: run only, no measurement.
- `ST_ARM`: waiting for the first reference edge.
- `ST_COUNT`: counting cycles until the second edge.
- `ST_HOLD`: result posted, waiting for `cal_en` to fall.

Its transitions are:
- `arm`: IDLE to ARM when `cal_en` is high.
- `start`: ARM to COUNT on a reference edge.
- `finish`: COUNT to HOLD on a reference edge.
- `overrun`: COUNT to HOLD when the count reaches the upper limit with no edge.
- `abort`: ARM or COUNT to IDLE when `cal_en` falls.
- `release`: HOLD to IDLE when `cal_en` falls.

Top module: `sec_trim_divider`

## Requirements
- R1: The reference input passes through a two-flop synchronizer. Only its low-to-high transition creates a measurement event, and a pulse held high for several cycles creates exactly one event.
- R2: While reset is active and right after it, `divisor` equals NOM_DIV (32768 by default), `cal_done` and `cal_err` are 0 and `tick` is 0.
- R3: With `cal_en` high, the first reference rising edge starts a count and the next one ends it. The stored divisor equals the number of clock cycles between the two reference rising edges, and `cal_done` goes to 1.
- R4: A measured count is accepted when it lies in NOM_DIV-TOL to NOM_DIV+TOL. Both limits are included.
- R5: A count below NOM_DIV-TOL is rejected. A count that would exceed NOM_DIV+TOL is also rejected, and this is flagged as soon as the counter reaches the upper limit without an edge. On rejection the divisor is unchanged, `cal_err` is 1 and `cal_done` is 0. The two flags are never 1 together.
- R6: `tick` is high for exactly one cycle, and successive ticks are exactly `divisor` cycles apart.
- R7: A newly stored divisor sets the spacing from the first tick after the store onward.
- R8: While `cal_en` is low, reference edges do not change the divisor. Lowering `cal_en` during ARM or COUNT abandons the measurement without changing the divisor.
- R9: `cal_done` and `cal_err` keep their values after `cal_en` falls. Both are cleared when the next calibration arms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_pulse | input | 1 | External one-second reference, asynchronous |
| cal_en | input | 1 | Calibration enable |
| tick | output | 1 | One-cycle seconds tick |
| divisor | output | DIV_W | Divide ratio in use |
| cal_done | output | 1 | Last calibration accepted |
| cal_err | output | 1 | Last calibration rejected |

## Verification
Some properties are checked by assertions on every cycle:
- the single-cycle width of reference events and ticks;
- the divisor staying inside the accepted window;
- the count never passing the upper limit;
- the divisor being held on a rejection and while calibration is off;
- the two result flags never being high together.

Other behaviour can only be shown by the bench's scenarios: that the stored value equals the reference period in cycles, that the exact window limits are accepted while their neighbours are rejected, that the tick spacing follows a new divisor from the next reload, and that an aborted or disabled calibration leaves the flags and divisor as expected. The bench covers these with random reference periods around the window and with directed limit, abort and disabled cases.

// File: rtl/trim_pkg.sv
package trim_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARM,
        ST_COUNT,
        ST_HOLD
    } cal_state_t;
endpackage

// File: rtl/trim_ref_sync.sv
module trim_ref_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_async,
    output logic ref_edge
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ref_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign ref_edge = sync_q & ~prev_q;

    // R1: a reference event never lasts more than one cycle
    assert_edge_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_edge |=> !ref_edge);
endmodule

// File: rtl/trim_cal_fsm.sv
module trim_cal_fsm
    import trim_pkg::*;
#(
    parameter int NOM_DIV = 32768,
    parameter int TOL     = 64,
    parameter int DIV_W   = $clog2(NOM_DIV + TOL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cal_en,
    input  logic             ref_edge,
    output logic [DIV_W-1:0] div_q,
    output logic             done_q,
    output logic             err_q
);
    localparam logic [DIV_W-1:0] MIN_V = DIV_W'(NOM_DIV - TOL);
    localparam logic [DIV_W-1:0] MAX_V = DIV_W'(NOM_DIV + TOL);
    localparam logic [DIV_W-1:0] NOM_V = DIV_W'(NOM_DIV);

    cal_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cal_en) state_d = ST_ARM;
            ST_ARM: begin
                if (!cal_en)       state_d = ST_IDLE;
                else if (ref_edge) state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!cal_en)                          state_d = ST_IDLE;
                else if (ref_edge || cnt_q == MAX_V)  state_d = ST_HOLD;
            end
            ST_HOLD:  if (!cal_en) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            div_q  <= NOM_V;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cal_en) begin
                        done_q <= 1'b0;
                        err_q  <= 1'b0;
                    end
                end
                ST_ARM: begin
                    if (cal_en && ref_edge) cnt_q <= DIV_W'(1);
                end
                ST_COUNT: begin
                    if (cal_en) begin
                        if (ref_edge) begin
                            if (cnt_q >= MIN_V) begin
                                div_q  <= cnt_q;
                                done_q <= 1'b1;
                            end else begin
                                err_q  <= 1'b1;
                            end
                        end else if (cnt_q == MAX_V) begin
                            err_q <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_HOLD: ;
                default: ;
            endcase
        end
    end

    // R4: the stored ratio always lies inside the accepted window
    assert_div_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (div_q >= MIN_V) && (div_q <= MAX_V));

    // R5: rejection leaves the previous ratio in place
    assert_err_keeps_div_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> (div_q == $past(div_q)));

    // R5: accepted and rejected results are exclusive
    assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && err_q));

    // R5: the measurement counter never runs past the upper limit
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT) |-> (cnt_q <= MAX_V));

    // R8: with calibration disabled the ratio holds
    assert_idle_keeps_div_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cal_en) |-> $stable(div_q));
endmodule

// File: rtl/trim_tick_gen.sv
module trim_tick_gen #(
    parameter int NOM_DIV = 32768,
    parameter int DIV_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick
);
    localparam logic [DIV_W-1:0] START_V = DIV_W'(NOM_DIV - 1);

    logic [DIV_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt_q <= START_V;
        else if (cnt_q == 0) cnt_q <= div_i - 1'b1;
        else                 cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);

    // R6: a tick is a single-cycle pulse
    assert_tick_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/sec_trim_divider.sv
module sec_trim_divider #(
    parameter int NOM_DIV = 32768,
    parameter int TOL     = 64,
    parameter int DIV_W   = $clog2(NOM_DIV + TOL + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             cal_en,
    output logic             tick,
    output logic [DIV_W-1:0] divisor,
    output logic             cal_done,
    output logic             cal_err
);
    logic ref_edge;

    trim_ref_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_async (ref_pulse),
        .ref_edge  (ref_edge)
    );

    trim_cal_fsm #(
        .NOM_DIV (NOM_DIV),
        .TOL     (TOL),
        .DIV_W   (DIV_W)
    ) u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .cal_en   (cal_en),
        .ref_edge (ref_edge),
        .div_q    (divisor),
        .done_q   (cal_done),
        .err_q    (cal_err)
    );

    trim_tick_gen #(
        .NOM_DIV (NOM_DIV),
        .DIV_W   (DIV_W)
    ) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .div_i (divisor),
        .tick  (tick)
    );
endmodule

// File: tb/sec_trim_divider_tb_top.sv
module sec_trim_divider_tb_top;
    localparam int NOM   = 256;
    localparam int TOL   = 16;
    localparam int W     = $clog2(NOM + TOL + 1);
    localparam int MIN_D = NOM - TOL;
    localparam int MAX_D = NOM + TOL;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ref_pulse = 1'b0;
    logic         cal_en = 1'b0;
    logic         tick;
    logic [W-1:0] divisor;
    logic         cal_done, cal_err;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    int model_div = NOM;
    bit finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sec_trim_divider #(.NOM_DIV(NOM), .TOL(TOL)) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse), .cal_en(cal_en),
        .tick(tick), .divisor(divisor), .cal_done(cal_done), .cal_err(cal_err)
    );

    function automatic bit in_window(int p);
        return (p >= MIN_D) && (p <= MAX_D);
    endfunction

    function automatic int exp_div(int p, int prev);
        return in_window(p) ? p : prev;
    endfunction

    task automatic check(string req, int actual, int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic pulse_ref();
        ref_pulse = 1'b1;
        repeat (4) @(negedge clk);
        ref_pulse = 1'b0;
    endtask

    // full calibration with a reference period of p cycles
    task automatic calibrate(int p, string req);
        @(negedge clk);
        cal_en = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 flags cleared on arm", int'(cal_done | cal_err), 0);
        pulse_ref();
        repeat (p - 4) @(negedge clk);
        pulse_ref();
        repeat (6) @(negedge clk);
        model_div = exp_div(p, model_div);
        check({req, " divisor"}, int'(divisor), model_div);
        check({req, " done"}, int'(cal_done), int'(in_window(p)));
        check({req, " err"}, int'(cal_err), int'(!in_window(p)));
        cal_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R9 flags held", int'(cal_done), int'(in_window(p)));
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!tick);
    endtask

    task automatic check_spacing(string req);
        int t0;
        wait_tick();
        wait_tick();
        t0 = cyc;
        @(negedge clk);
        check("R6 tick width", int'(tick), 0);
        wait_tick();
        check(req, cyc - t0, model_div);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R2 divisor in reset", int'(divisor), NOM);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 divisor", int'(divisor), NOM);
        check("R2 done", int'(cal_done), 0);
        check("R2 err", int'(cal_err), 0);
        check("R2 tick", int'(tick), 0);
        check_spacing("R6 spacing after reset");

        // R3 nominal-area calibration and R7 new spacing
        calibrate(250, "R3 in-window");
        check_spacing("R7 spacing follows new divisor");

        // R4 window limits and R5 neighbours
        calibrate(MIN_D, "R4 lower limit");
        calibrate(MAX_D, "R4 upper limit");
        calibrate(MIN_D - 1, "R5 below window");
        calibrate(MAX_D + 1, "R5 overrun");
        check_spacing("R7 spacing after reject");

        // R1 long reference pulse still gives one event: period measured edge to edge
        @(negedge clk);
        cal_en = 1'b1;
        repeat (3) @(negedge clk);
        ref_pulse = 1'b1;
        repeat (40) @(negedge clk);
        ref_pulse = 1'b0;
        repeat (260 - 40) @(negedge clk);
        pulse_ref();
        repeat (6) @(negedge clk);
        model_div = 260;
        check("R1 long pulse divisor", int'(divisor), 260);
        cal_en = 1'b0;
        repeat (2) @(negedge clk);

        // R8 abort mid-count
        cal_en = 1'b1;
        repeat (3) @(negedge clk);
        pulse_ref();
        repeat (50) @(negedge clk);
        cal_en = 1'b0;
        repeat (200) @(negedge clk);
        pulse_ref();
        repeat (6) @(negedge clk);
        check("R8 abort divisor", int'(divisor), model_div);
        check("R8 abort flags", int'(cal_done | cal_err), 0);

        // R8 edges ignored while disabled
        pulse_ref();
        repeat (244) @(negedge clk);
        pulse_ref();
        repeat (6) @(negedge clk);
        check("R8 disabled divisor", int'(divisor), model_div);
        check_spacing("R8 spacing unchanged");

        // random periods around the window
        for (int i = 0; i < 20; i++) begin
            int p;
            p = MIN_D - 24 + int'($urandom_range(0, MAX_D - MIN_D + 48));
            calibrate(p, "R3/R5 random");
            if (i % 4 == 0) check_spacing("R7 random spacing");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule